// File: doc/BRIEF.md
# Outbound Transaction Ordering Queue

This block holds outbound bus transactions of five classes in a small queue and decides, every cycle, which one is sent next. Producers push a transaction through a valid/ready port that carries a 3-bit class code and a payload tag. The payload itself is kept elsewhere; the queue stores only the class and the tag. Each class has its own downstream ready input. A single issue port shows the selected transaction, and the entry counts as consumed in any cycle where that port is valid.

Order is kept by an age matrix. Every new entry is recorded as younger than every entry already held. An entry may be issued only when its own class is ready downstream and it is not held back by an older entry. The hold-back rules are these. Posted writes (which include messages) are barriers to everything behind them. Read requests and configuration writes hold each other back. Completions may overtake anything except a posted write. Among the entries that are free to go, the oldest one wins.

Top module: `txn_order_queue`

## Requirements
- R1: Class codes are 0 posted write or message, 1 read request, 2 configuration write request, 3 read completion, 4 configuration or I/O write completion. A transaction offered with code 5, 6 or 7 is accepted by the handshake, discarded, and never issued.
- R2: The queue holds 8 entries. `enq_ready` is low exactly when 8 entries are held. An offer made while it is low is not taken.
- R3: An entry is issued only while bit `dn_ready[c]` of its class code c is high. At most one entry is issued per cycle. The issue outputs are combinational from the held state and the readies, and the entry is removed at the clock edge ending a cycle in which `iss_valid` is high.
- R4: No transaction is issued while an older posted write is still held.
- R5: A posted write may be issued ahead of older read requests, configuration writes and completions of either type.
- R6: A read request or configuration write is never issued ahead of an older read request or configuration write.
- R7: Read requests and configuration writes may be issued ahead of older completions of either type.
- R8: Completions of either type may be issued ahead of older read requests, configuration writes and completions.
- R9: When several entries are eligible, the oldest one is issued.
- R10: An entry cannot be issued in the cycle in which it is written. It becomes eligible in the following cycle.
- R11: Synchronous active-high reset empties the queue: `iss_valid` is low and `enq_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Offer of a new transaction |
| enq_ready | output | 1 | Queue can take a transaction |
| enq_cls | input | 3 | Class code of the offered transaction |
| enq_tag | input | TAG_W (8) | Payload tag of the offered transaction |
| dn_ready | input | 5 | Downstream ready, one bit per class code |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_cls | output | 3 | Class code of the issued entry |
| iss_tag | output | TAG_W (8) | Payload tag of the issued entry |

## Verification
The bench builds the queue with its defaults: a depth of 8 and an 8-bit tag. Because the queue is that small, the full and refused-offer cases, and a complete oldest-first drain of every slot, can be reached in a few dozen cycles. A table of three-entry scenarios places pairs of classes in both age orders under selected ready masks, so each cell of the pass matrix that matters is exercised. Directed cases cover discarded illegal codes, the same-cycle issue block on a fresh entry, and reset in the middle of operation.

// File: rtl/txn_order_pkg.sv
package txn_order_pkg;

    localparam int NUM_CLS = 5;
    localparam int CLS_W   = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_PW = 3'd0,  // posted write or message
        CLS_RD = 3'd1,  // read request
        CLS_CW = 3'd2,  // configuration write request
        CLS_RC = 3'd3,  // read completion
        CLS_WC = 3'd4   // configuration / I/O write completion
    } txn_cls_e;

    function automatic logic cls_legal(input logic [CLS_W-1:0] code);
        return code < CLS_W'(NUM_CLS);
    endfunction

    function automatic logic is_req_rw(input txn_cls_e c);
        return (c == CLS_RD) || (c == CLS_CW);
    endfunction

    // true when a younger entry of class yng may go ahead of an older one of class old
    function automatic logic may_pass(input txn_cls_e yng, input txn_cls_e old);
        if (old == CLS_PW)
            return 1'b0;
        if (is_req_rw(yng) && is_req_rw(old))
            return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic cls_ready(input logic [NUM_CLS-1:0] rdy, input txn_cls_e c);
        case (c)
            CLS_PW:  return rdy[0];
            CLS_RD:  return rdy[1];
            CLS_CW:  return rdy[2];
            CLS_RC:  return rdy[3];
            CLS_WC:  return rdy[4];
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/txn_slot_find.sv
module txn_slot_find #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] valid_i,
    output logic [DEPTH-1:0] free_oh_o,
    output logic             full_o
);
    always_comb begin
        free_oh_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_oh_o    = '0;
                free_oh_o[i] = 1'b1;
            end
        end
        full_o = &valid_i;
    end
endmodule

// File: rtl/txn_age_matrix.sv
module txn_age_matrix #(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DEPTH-1:0]            valid_i,
    input  logic [DEPTH-1:0]            alloc_i,
    input  logic [DEPTH-1:0]            release_i,
    output logic [DEPTH-1:0][DEPTH-1:0] older_o
);
    // older_o[i][j] set: entry i entered before entry j
    logic [DEPTH-1:0][DEPTH-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (release_i[i] || release_i[j] || alloc_i[i])
                        older_q[i][j] <= 1'b0;
                    else if (alloc_i[j])
                        older_q[i][j] <= valid_i[i];
                end
            end
        end
    end

    assign older_o = older_q;
endmodule

// File: rtl/txn_pick.sv
module txn_pick
    import txn_order_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0]            valid_i,
    input  txn_cls_e [DEPTH-1:0]        cls_i,
    input  logic [NUM_CLS-1:0]          dn_ready_i,
    input  logic [DEPTH-1:0][DEPTH-1:0] older_i,
    output logic [DEPTH-1:0]            grant_o
);
    logic [DEPTH-1:0] elig;
    logic [DEPTH-1:0] blocked;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            logic [DEPTH-1:0] ahead;  // valid entries older than i
            always_comb begin
                for (int j = 0; j < DEPTH; j++)
                    ahead[j] = valid_i[j] & older_i[j][i];
                blocked[i] = 1'b0;
                for (int j = 0; j < DEPTH; j++)
                    if (ahead[j] && !may_pass(cls_i[i], cls_i[j]))
                        blocked[i] = 1'b1;
                elig[i] = valid_i[i] & cls_ready(dn_ready_i, cls_i[i]) & ~blocked[i];
            end
            assign grant_o[i] = elig[i] & ~|(elig & ahead);
        end
    endgenerate
endmodule

// File: rtl/txn_order_queue.sv
module txn_order_queue
    import txn_order_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enq_valid,
    output logic                 enq_ready,
    input  logic [CLS_W-1:0]     enq_cls,
    input  logic [TAG_W-1:0]     enq_tag,
    input  logic [NUM_CLS-1:0]   dn_ready,
    output logic                 iss_valid,
    output logic [CLS_W-1:0]     iss_cls,
    output logic [TAG_W-1:0]     iss_tag
);
    logic [DEPTH-1:0]            valid_q;
    txn_cls_e [DEPTH-1:0]        cls_q;
    logic [DEPTH-1:0][TAG_W-1:0] tag_q;

    logic [DEPTH-1:0]            free_oh;
    logic                        full;
    logic [DEPTH-1:0]            alloc;
    logic [DEPTH-1:0]            grant;
    logic [DEPTH-1:0][DEPTH-1:0] older;

    txn_slot_find #(.DEPTH(DEPTH)) u_find (
        .valid_i   (valid_q),
        .free_oh_o (free_oh),
        .full_o    (full)
    );

    assign enq_ready = ~full;
    assign alloc     = (enq_valid && !full && cls_legal(enq_cls)) ? free_oh : '0;

    txn_age_matrix #(.DEPTH(DEPTH)) u_age (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (valid_q),
        .alloc_i   (alloc),
        .release_i (grant),
        .older_o   (older)
    );

    txn_pick #(.DEPTH(DEPTH)) u_pick (
        .valid_i    (valid_q),
        .cls_i      (cls_q),
        .dn_ready_i (dn_ready),
        .older_i    (older),
        .grant_o    (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            cls_q   <= {DEPTH{CLS_PW}};
            tag_q   <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc[i]) begin
                    valid_q[i] <= 1'b1;
                    cls_q[i]   <= txn_cls_e'(enq_cls);
                    tag_q[i]   <= enq_tag;
                end else if (grant[i]) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        iss_cls = '0;
        iss_tag = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i]) begin
                iss_cls = iss_cls | cls_q[i];
                iss_tag = iss_tag | tag_q[i];
            end
        end
        iss_valid = |grant;
    end
endmodule

// File: rtl/txn_order_queue_chk.sv
module txn_order_queue_chk
    import txn_order_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        enq_valid,
    input logic                        enq_ready,
    input logic [CLS_W-1:0]            enq_cls,
    input logic [NUM_CLS-1:0]          dn_ready,
    input logic                        iss_valid,
    input logic [CLS_W-1:0]            iss_cls,
    input logic [DEPTH-1:0]            valid_q,
    input txn_cls_e [DEPTH-1:0]        cls_q,
    input logic [DEPTH-1:0][DEPTH-1:0] older,
    input logic [DEPTH-1:0]            grant
);
    localparam int OCC_W = $clog2(DEPTH + 1) + 1;
    logic [OCC_W-1:0] occ;
    logic             take;

    assign take = enq_valid && enq_ready && (enq_cls < CLS_W'(NUM_CLS));

    always_ff @(posedge clk) begin
        if (rst)
            occ <= '0;
        else
            occ <= occ + OCC_W'(take) - OCC_W'(iss_valid);
    end

    logic pw_jump, rw_jump, age_bad;
    always_comb begin
        pw_jump = 1'b0;
        rw_jump = 1'b0;
        age_bad = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (grant[i] && valid_q[j] && older[j][i]) begin
                    if (cls_q[j] == CLS_PW) pw_jump = 1'b1;
                    if (is_req_rw(cls_q[i]) && is_req_rw(cls_q[j])) rw_jump = 1'b1;
                end
                if (i < j && valid_q[i] && valid_q[j] && !(older[i][j] ^ older[j][i]))
                    age_bad = 1'b1;
            end
        end
    end

    // R2
    full_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == OCC_W'(DEPTH)) == !enq_ready);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));
    // R3
    ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> cls_ready(dn_ready, txn_cls_e'(iss_cls)));
    // R3
    single_issue_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R4
    pw_barrier_chk: assert property (@(posedge clk) disable iff (rst)
        !pw_jump);
    // R6
    rw_order_chk: assert property (@(posedge clk) disable iff (rst)
        !rw_jump);
    // R9
    age_total_chk: assert property (@(posedge clk) disable iff (rst)
        !age_bad);
    // R10
    fresh_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !iss_valid);
    // R11
    reset_empty_chk: assert property (@(posedge clk)
        $past(rst) |-> (!iss_valid && enq_ready));
endmodule

bind txn_order_queue txn_order_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enq_valid (enq_valid),
    .enq_ready (enq_ready),
    .enq_cls   (enq_cls),
    .dn_ready  (dn_ready),
    .iss_valid (iss_valid),
    .iss_cls   (iss_cls),
    .valid_q   (valid_q),
    .cls_q     (cls_q),
    .older     (older),
    .grant     (grant)
);

// File: tb/txn_order_queue_tb.sv
module txn_order_queue_tb;
    localparam int TAG_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enq_valid = 1'b0;
    logic             enq_ready;
    logic [2:0]       enq_cls = '0;
    logic [TAG_W-1:0] enq_tag = '0;
    logic [4:0]       dn_ready = '0;
    logic             iss_valid;
    logic [2:0]       iss_cls;
    logic [TAG_W-1:0] iss_tag;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;  // 50 MHz

    txn_order_queue #(.DEPTH(8), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_cls(enq_cls), .enq_tag(enq_tag),
        .dn_ready(dn_ready),
        .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_tag(iss_tag)
    );

    // class codes: 0 PW, 1 RD, 2 CW, 3 RC, 4 WC; ready bit index = class code
    typedef struct packed {
        logic [2:0] c0;   // oldest
        logic [2:0] c1;
        logic [2:0] c2;   // youngest
        logic [4:0] rdy;
        logic       ev;   // expect an issue
        logic [1:0] ei;   // expected entry (tag)
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 3'd1, 3'd3, 5'b11111, 1'b1, 2'd0},  // R9 oldest wins
        '{3'd0, 3'd1, 3'd3, 5'b01010, 1'b0, 2'd0},  // R4 PW blocks all
        '{3'd1, 3'd0, 3'd3, 5'b01001, 1'b1, 2'd1},  // R5 PW passes RD
        '{3'd1, 3'd2, 3'd3, 5'b01100, 1'b1, 2'd2},  // R8 RC passes RD, CW
        '{3'd1, 3'd2, 3'd4, 5'b00100, 1'b0, 2'd0},  // R6 CW behind RD
        '{3'd2, 3'd1, 3'd4, 5'b00010, 1'b0, 2'd0},  // R6 RD behind CW
        '{3'd3, 3'd1, 3'd4, 5'b10010, 1'b1, 2'd1},  // R7 RD passes RC
        '{3'd3, 3'd4, 3'd3, 5'b10000, 1'b1, 2'd1},  // R8 WC passes RC
        '{3'd4, 3'd3, 3'd2, 5'b01100, 1'b1, 2'd1},  // R9 RC older than CW
        '{3'd1, 3'd3, 3'd0, 5'b00001, 1'b1, 2'd2},  // R5 PW passes RD, RC
        '{3'd0, 3'd0, 3'd3, 5'b00001, 1'b1, 2'd0},  // R4 PW behind PW
        '{3'd3, 3'd3, 3'd3, 5'b00000, 1'b0, 2'd0}   // R3 nothing ready
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        enq_valid = 1'b0;
        dn_ready = '0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic [2:0] c, input logic [TAG_W-1:0] t);
        enq_valid = 1'b1;
        enq_cls   = c;
        enq_tag   = t;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    initial begin
        #4000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11 reset state
        do_reset();
        #5;
        check("R11 iss_valid after reset", iss_valid, 0);
        check("R11 enq_ready after reset", enq_ready, 1);

        // pass-rule table
        for (int v = 0; v < NV; v++) begin
            do_reset();
            push(VECS[v].c0, 8'd0);
            push(VECS[v].c1, 8'd1);
            push(VECS[v].c2, 8'd2);
            dn_ready = VECS[v].rdy;
            #5;
            check($sformatf("R4-table vec%0d valid", v), iss_valid, VECS[v].ev);
            if (VECS[v].ev)
                check($sformatf("table vec%0d tag", v), iss_tag, {6'd0, VECS[v].ei});
            @(negedge clk);
            dn_ready = '0;
        end

        // R2 fill, refuse, then R9 drain oldest first
        do_reset();
        for (int k = 0; k < 8; k++) push(3'd3, 8'(8'h10 + k));
        #5;
        check("R2 enq_ready low when full", enq_ready, 0);
        @(negedge clk);
        push(3'd3, 8'hEE);  // refused offer
        dn_ready = 5'b01000;
        for (int k = 0; k < 8; k++) begin
            #5;
            check("R9 drain order", {iss_valid, iss_tag}, {1'b1, 8'(8'h10 + k)});
            @(negedge clk);
        end
        #5;
        check("R2 refused offer not held", iss_valid, 0);
        check("R2 enq_ready back high", enq_ready, 1);
        @(negedge clk);

        // R10 fresh entry not issued in its write cycle
        do_reset();
        dn_ready = 5'b11111;
        enq_valid = 1'b1;
        enq_cls   = 3'd1;
        enq_tag   = 8'h5A;
        #5;
        check("R10 no issue in write cycle", iss_valid, 0);
        @(negedge clk);
        enq_valid = 1'b0;
        #5;
        check("R10 issue next cycle", {iss_valid, iss_cls, iss_tag}, {1'b1, 3'd1, 8'h5A});
        @(negedge clk);

        // R1 illegal class codes discarded
        do_reset();
        dn_ready = 5'b11111;
        push(3'd6, 8'h66);
        push(3'd5, 8'h55);
        #5;
        check("R1 illegal code not issued", iss_valid, 0);
        push(3'd4, 8'h44);
        #5;
        check("R1 WC code 4 issued", {iss_valid, iss_cls, iss_tag}, {1'b1, 3'd4, 8'h44});
        @(negedge clk);

        // R11 reset mid-operation
        dn_ready = '0;
        for (int k = 0; k < 8; k++) push(3'd0, 8'(k));
        do_reset();
        dn_ready = 5'b11111;
        #5;
        check("R11 reset empties queue", {iss_valid, enq_ready}, 2'b01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule